// File: doc/BRIEF.md
# 32-bit Integer Arithmetic Logic Unit

This block is the execute-stage datapath of a small load-store processor. It is purely combinational. Two operands, a 4-bit operation code and a separate shift count come in, and a result word comes out. Two flags come out with it: one marks a result of zero, the other marks a signed overflow on the trapping add and subtract codes. The block has no registers. The surrounding pipeline latches its inputs and outputs, and it decides what to do about an overflow.

The operation codes are grouped by their top two bits:
- `00` selects the bitwise operations.
- `01` selects add and subtract.
- `10` selects the compares.
- `11` selects the shifts.

Shifts always move the first operand, and they use the dedicated shift-count input, never the second operand. One adder serves add, subtract and both compares. This lets the signed compare derive its answer from the true sign of the difference, even when the difference overflows.

Top module: `int_alu32`

## Requirements
- R1: Codes 0000, 0001, 0010 and 0011 give the bitwise AND, OR, XOR and NOR of the two operands.
- R2: Codes 0100 and 0101 give the sum of the operands modulo 2^32. Codes 0110 and 0111 give the first operand minus the second, modulo 2^32.
- R3: The overflow flag is high on code 0100 when the sum leaves the signed 32-bit range, and on code 0110 when the difference leaves that range.
- R4: The overflow flag is low for every code other than 0100 and 0110, including 0101 and 0111 when their signed value would wrap.
- R5: Code 1010 gives 1 when the first operand is less than the second as signed two's-complement numbers, and 0 otherwise. This holds even when their difference overflows.
- R6: Code 1011 gives 1 when the first operand is less than the second as unsigned numbers, and 0 otherwise.
- R7: Code 1100 shifts the first operand left by the shift count, which can be 0 to 31, and fills the vacated bits with zero.
- R8: Code 1110 shifts the first operand right by the shift count and fills the vacated bits with zero.
- R9: Code 1111 shifts the first operand right by the shift count and fills the vacated bits with copies of its bit 31.
- R10: The unassigned codes 1000, 1001 and 1101 give an all-zero result with the overflow flag low.
- R11: The zero flag is high exactly when the 32-bit result is zero, for every code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_x | input | 32 | First operand; the value that is shifted |
| opnd_y | input | 32 | Second operand |
| op_sel | input | 4 | Operation code |
| shift_cnt | input | 5 | Shift distance for the shift codes |
| res | output | 32 | Result word |
| res_zero | output | 1 | High when res is zero |
| sgn_ovf | output | 1 | Signed overflow on the trapping add and subtract codes |

## Verification
The bench aims at the signed-range edges. It adds 0x7FFFFFFF and 1, and it subtracts 1 from 0x80000000. A design that forgets to invert the sign of the second operand when checking for overflow misses the subtract case. A design that raises the flag on the non-trapping codes shows it on 0101 and 0111. For the signed compare, the bench uses 0x80000000 against 1. A design that reads only the raw sign bit of the difference answers 0 there instead of 1. The bench drives shift counts of 0 and 31, sign-fill cases for the arithmetic right shift, and random operands on the unassigned codes, where a stray decode would leak a non-zero word.

// File: rtl/int_alu32.sv
module int_alu32 #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]         opnd_x,
  input  logic [WIDTH-1:0]         opnd_y,
  input  logic [3:0]               op_sel,
  input  logic [$clog2(WIDTH)-1:0] shift_cnt,
  output logic [WIDTH-1:0]         res,
  output logic                     res_zero,
  output logic                     sgn_ovf
);
  localparam int MSB = WIDTH - 1;

  logic             do_sub;
  logic [WIDTH-1:0] addend;
  logic [WIDTH-1:0] sum;
  logic             carry;
  logic             wrap;
  logic             lt_signed;
  logic             lt_unsigned;

  assign do_sub = op_sel[1] | op_sel[3];
  assign addend = do_sub ? ~opnd_y : opnd_y;
  assign {carry, sum} = {1'b0, opnd_x} + {1'b0, addend} + {{WIDTH{1'b0}}, do_sub};
  assign wrap = (opnd_x[MSB] == addend[MSB]) && (sum[MSB] != opnd_x[MSB]);

  assign lt_signed   = sum[MSB] ^ wrap;
  assign lt_unsigned = ~carry;

  always_comb begin
    case (op_sel)
      4'b0000: res = opnd_x & opnd_y;
      4'b0001: res = opnd_x | opnd_y;
      4'b0010: res = opnd_x ^ opnd_y;
      4'b0011: res = ~(opnd_x | opnd_y);
      4'b0100, 4'b0101, 4'b0110, 4'b0111: res = sum;
      4'b1010: res = {{MSB{1'b0}}, lt_signed};
      4'b1011: res = {{MSB{1'b0}}, lt_unsigned};
      4'b1100: res = opnd_x << shift_cnt;
      4'b1110: res = opnd_x >> shift_cnt;
      4'b1111: res = $unsigned($signed(opnd_x) >>> shift_cnt);
      default: res = '0;
    endcase
  end

  assign res_zero = ~|res;
  assign sgn_ovf  = wrap && (op_sel == 4'b0100 || op_sel == 4'b0110);
endmodule

module int_alu32_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0]         opnd_x,
  input logic [WIDTH-1:0]         opnd_y,
  input logic [3:0]               op_sel,
  input logic [$clog2(WIDTH)-1:0] shift_cnt,
  input logic [WIDTH-1:0]         res,
  input logic                     res_zero,
  input logic                     sgn_ovf
);
  always_comb begin
    if (sgn_ovf)
      assert_ovf_only_trapping_R4: assert (op_sel == 4'b0100 || op_sel == 4'b0110);
    if (op_sel == 4'b1000 || op_sel == 4'b1001 || op_sel == 4'b1101)
      assert_reserved_quiet_R10: assert (res_zero && !sgn_ovf);
    if (op_sel == 4'b1010 || op_sel == 4'b1011)
      assert_compare_is_bit_R5: assert (res[WIDTH-1:1] == '0);
    if (op_sel[3:2] == 2'b11 && op_sel != 4'b1101 && shift_cnt == '0)
      assert_shift_zero_identity_R7: assert (res == opnd_x);
    if (op_sel == 4'b0010 && opnd_x == opnd_y)
      assert_xor_self_zero_R11: assert (res_zero);
    if (op_sel == 4'b0101 && opnd_y == '0)
      assert_add_identity_R2: assert (res == opnd_x && !sgn_ovf);
  end
endmodule

bind int_alu32 int_alu32_chk #(.WIDTH(WIDTH)) u_chk (
  .opnd_x(opnd_x), .opnd_y(opnd_y), .op_sel(op_sel), .shift_cnt(shift_cnt),
  .res(res), .res_zero(res_zero), .sgn_ovf(sgn_ovf)
);

// File: tb/int_alu32_bench.sv
`timescale 1ns/1ps
module int_alu32_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [31:0] opnd_x, opnd_y, res;
  logic [3:0]  op_sel;
  logic [4:0]  shift_cnt;
  logic        res_zero, sgn_ovf;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int_alu32 u_int_alu32 (
    .opnd_x(opnd_x), .opnd_y(opnd_y), .op_sel(op_sel), .shift_cnt(shift_cnt),
    .res(res), .res_zero(res_zero), .sgn_ovf(sgn_ovf)
  );

  function automatic logic [31:0] ref_res(input logic [31:0] x, input logic [31:0] y,
                                          input logic [3:0] op, input logic [4:0] n);
    logic [31:0] r;
    longint sx, sy;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    r = '0;
    case (op)
      4'd0: r = x & y;
      4'd1: r = x | y;
      4'd2: r = x ^ y;
      4'd3: r = ~(x | y);
      4'd4, 4'd5: r = 32'((64'(x) + 64'(y)));
      4'd6, 4'd7: r = 32'((64'(x) - 64'(y)));
      4'd10: r = {31'd0, sx < sy};
      4'd11: r = {31'd0, x < y};
      4'd12: for (int i = 0; i < 32; i++) r[i] = (i >= int'(n)) ? x[i - int'(n)] : 1'b0;
      4'd14: for (int i = 0; i < 32; i++) r[i] = (i + int'(n) < 32) ? x[i + int'(n)] : 1'b0;
      4'd15: for (int i = 0; i < 32; i++) r[i] = (i + int'(n) < 32) ? x[i + int'(n)] : x[31];
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic ref_ovf(input logic [31:0] x, input logic [31:0] y, input logic [3:0] op);
    longint v;
    v = 0;
    if (op == 4'd4) v = longint'($signed(x)) + longint'($signed(y));
    else if (op == 4'd6) v = longint'($signed(x)) - longint'($signed(y));
    return (v > 64'sd2147483647) || (v < -64'sd2147483648);
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1, 4'd2, 4'd3: return "R1";
      4'd4, 4'd5, 4'd6, 4'd7: return "R2";
      4'd10: return "R5";
      4'd11: return "R6";
      4'd12: return "R7";
      4'd14: return "R8";
      4'd15: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic expect_bit(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b (op %b x %h y %h n %0d)",
               tag, act, exp, op_sel, opnd_x, opnd_y, shift_cnt);
    end
  endtask

  task automatic apply(input logic [31:0] x, input logic [31:0] y,
                       input logic [3:0] op, input logic [4:0] n);
    logic [31:0] er;
    logic        eo;
    @(posedge clk);
    opnd_x = x; opnd_y = y; op_sel = op; shift_cnt = n;
    @(negedge clk);
    er = ref_res(x, y, op, n);
    eo = ref_ovf(x, y, op);
    n_chk++;
    if (res !== er) begin
      n_bad++;
      $display("FAIL %s: result actual %h expected %h (op %b x %h y %h n %0d)",
               tag_of(op), res, er, op, x, y, n);
    end
    if (op == 4'd4 || op == 4'd6) expect_bit("R3", sgn_ovf, eo);
    else expect_bit("R4", sgn_ovf, 1'b0);
    expect_bit("R11", res_zero, er == 32'd0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    opnd_x = '0; opnd_y = '0; op_sel = '0; shift_cnt = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_chk++;
    if (res !== 32'd0) begin n_bad++; $display("FAIL R1: reset result actual %h expected 0", res); end
    expect_bit("R11", res_zero, 1'b1);

    apply(32'h7FFF_FFFF, 32'h1, 4'd4, 0);        // R3 positive wrap
    apply(32'h7FFF_FFFF, 32'h1, 4'd5, 0);        // R4 unsigned add quiet
    apply(32'h8000_0000, 32'h1, 4'd6, 0);        // R3 subtract wrap
    apply(32'h8000_0000, 32'h1, 4'd7, 0);        // R4
    apply(32'h0, 32'h8000_0000, 4'd6, 0);        // R3 negate min
    apply(32'h8000_0000, 32'h8000_0000, 4'd4, 0);// R3 negative wrap
    apply(32'h5, 32'h5, 4'd6, 0);                // R11 zero difference
    apply(32'h8000_0000, 32'h1, 4'd10, 0);       // R5 with overflowing difference
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'd10, 0);
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd10, 0);
    apply(32'h0, 32'hFFFF_FFFF, 4'd11, 0);       // R6
    apply(32'hFFFF_FFFF, 32'h0, 4'd11, 0);
    apply(32'hDEAD_BEEF, 32'h0, 4'd12, 0);       // R7 count zero
    apply(32'hDEAD_BEEF, 32'h0, 4'd12, 31);
    apply(32'hDEAD_BEEF, 32'h0, 4'd14, 31);      // R8
    apply(32'h8000_0000, 32'h0, 4'd15, 31);      // R9 sign fill
    apply(32'h4000_0000, 32'h0, 4'd15, 30);
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd8, 7);// R10
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd9, 7);
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd13, 7);
    apply(32'h0, 32'h0, 4'd3, 0);                // R1 NOR all ones
    apply(32'h1234_5678, 32'h1234_5678, 4'd2, 0);

    for (int k = 0; k < 3000; k++) begin
      logic [31:0] x, y;
      int sel;
      x = $urandom();
      y = $urandom();
      sel = $urandom_range(0, 3);
      if (sel == 0) y = x;
      else if (sel == 1) y = {x[31], y[30:0]};
      apply(x, y, 4'($urandom_range(0, 15)), 5'($urandom_range(0, 31)));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule